// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the error bookkeeping of a CAN node. It holds an 8-bit transmit error counter and an 8-bit receive error counter. From them it derives a 2-bit confinement state: error active, error passive or bus off. A protocol engine drives it with single-cycle strobes. These report a transmit or receive error (each with a weight), a successful transmission or reception, and whether the transmit error was an acknowledge error. A separate bit-time strobe, together with the sampled bus level, drives recovery from bus off.

When the transmit count would pass 255, the node goes bus off, the transmit counter clears and a one-cycle interrupt pulse is raised. Recovery reuses the transmit counter. An internal counter counts runs of 11 consecutive recessive bits, and each completed run adds one to the transmit counter. At 128 runs the node returns to error active with both counters at zero.

A test/freeze mode lets the counters be preloaded through a shared write data bus.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, tec=0, rec=0, state=2'b00 (error active) and busoff_irq=0.
- R2: Outside bus off, if tec+amount or rec+amount reaches 128 or more (without passing 255 on tec), the state becomes 2'b01 (error passive) on the next clock.
- R3: From error passive, the state returns to 2'b00 when a decrement leaves both counters at 127 or less.
- R4: A transmit error whose tec+amount exceeds 255 with ack_err=0 sets the state to 2'b10 (bus off) and clears tec on the next clock. It also raises busoff_irq for exactly that one cycle.
- R5: In bus off, each run of 11 consecutive bit_tick cycles with bit_val=1 (recessive) adds one to tec. A bit_tick with bit_val=0 (dominant) clears the run count and leaves tec unchanged.
- R6: When recovery brings tec to 128, the state becomes 2'b00 and both tec and rec become 0.
- R7: A transmit error with ack_err=1 that would take tec past 255 instead holds tec at 255, and the state does not become bus off.
- R8: When rec is 128 or more, receive errors leave it unchanged, and a successful reception reloads it to 127.
- R9: tx_ok and rx_ok each decrement their counter by one, saturating at 0. An error strobe in the same cycle takes priority over the success strobe for the same counter.
- R10: In bus off, tx_err_inc, rx_err_inc, tx_ok and rx_ok have no effect on tec, rec or the state.
- R11: tec_wr/rec_wr load wr_data only while test_mode=1, and are ignored otherwise. Outside bus off, a load recomputes the state from the new counter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err_inc | input | 1 | Transmit error strobe |
| tx_err_amt | input | AMT_W | Transmit error weight |
| ack_err | input | 1 | Qualifies tx_err_inc as an acknowledge error |
| rx_err_inc | input | 1 | Receive error strobe |
| rx_err_amt | input | AMT_W | Receive error weight |
| tx_ok | input | 1 | Successful transmission strobe |
| rx_ok | input | 1 | Successful reception strobe |
| bit_tick | input | 1 | One pulse per bus bit time |
| bit_val | input | 1 | Sampled bus level, 1 = recessive |
| test_mode | input | 1 | Enables counter writes |
| tec_wr | input | 1 | Load tec from wr_data |
| rec_wr | input | 1 | Load rec from wr_data |
| wr_data | input | 8 | Counter load value |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| state | output | 2 | 00 active, 01 passive, 1x bus off |
| busoff_irq | output | 1 | One-cycle pulse on entry to bus off |

## Verification
The bench preloads every transmit count from 0 to 255 and applies a weighted error. This catches an off-by-one in the passive threshold at 128 or in the bus-off threshold at 256. A design that got either wrong would report the wrong state or fail to clear tec. It likewise sweeps every receive count. That catches a counter that keeps climbing past 127, and a successful reception that decrements instead of reloading to 127. Recovery is driven with a dominant bit inside a recessive run and then through all 128 runs. A design that kept a partial run, or that dropped its error strobes late in bus off, would leave bus off at the wrong moment. An acknowledge error at 250 checks that a passive node does not go bus off on acknowledge errors alone.

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int AMT_W      = 4,
  parameter int RECOV_BITS = 11,
  parameter int RECOV_SEQ  = 128,
  parameter int REC_RELOAD = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_inc,
  input  logic [AMT_W-1:0] tx_err_amt,
  input  logic             ack_err,
  input  logic             rx_err_inc,
  input  logic [AMT_W-1:0] rx_err_amt,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             bit_tick,
  input  logic             bit_val,
  input  logic             test_mode,
  input  logic             tec_wr,
  input  logic             rec_wr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       tec,
  output logic [7:0]       rec,
  output logic [1:0]       state,
  output logic             busoff_irq
);
  localparam logic [1:0] ACTIVE  = 2'b00;
  localparam logic [1:0] PASSIVE = 2'b01;
  localparam logic [1:0] BUSOFF  = 2'b10;
  localparam int RB_W = $clog2(RECOV_BITS + 1);

  logic [RB_W-1:0] run, run_n;
  logic [7:0]      tec_n, rec_n;
  logic [1:0]      state_n;
  logic            irq_n;

  wire [8:0] tx_sum = {1'b0, tec} + 9'(tx_err_amt);
  wire [8:0] rx_sum = {1'b0, rec} + 9'(rx_err_amt);
  wire       bus_off = state[1];
  wire       wr_any  = test_mode && (tec_wr || rec_wr);

  always_comb begin
    tec_n   = tec;
    rec_n   = rec;
    state_n = state;
    run_n   = run;
    irq_n   = 1'b0;
    if (wr_any) begin
      if (tec_wr) tec_n = wr_data;
      if (rec_wr) rec_n = wr_data;
      if (!bus_off) state_n = (tec_n[7] || rec_n[7]) ? PASSIVE : ACTIVE;
    end else if (bus_off) begin
      if (bit_tick) begin
        if (!bit_val) run_n = '0;
        else if (run == RB_W'(RECOV_BITS - 1)) begin
          run_n = '0;
          tec_n = tec + 8'd1;
          if (tec_n == 8'(RECOV_SEQ)) begin
            tec_n   = '0;
            rec_n   = '0;
            state_n = ACTIVE;
          end
        end else run_n = run + RB_W'(1);
      end
    end else begin
      if (tx_err_inc) begin
        if (!tx_sum[8]) tec_n = tx_sum[7:0];
        else if (ack_err) tec_n = 8'hFF;
        else begin
          tec_n   = '0;
          state_n = BUSOFF;
          irq_n   = 1'b1;
          run_n   = '0;
        end
      end else if (tx_ok && tec != 8'd0) tec_n = tec - 8'd1;
      if (rx_err_inc) begin
        if (!rec[7]) rec_n = rx_sum[8] ? 8'hFF : rx_sum[7:0];
      end else if (rx_ok) begin
        if (rec[7]) rec_n = 8'(REC_RELOAD);
        else if (rec != 8'd0) rec_n = rec - 8'd1;
      end
      if (state_n != BUSOFF) state_n = (tec_n[7] || rec_n[7]) ? PASSIVE : ACTIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec        <= '0;
      rec        <= '0;
      state      <= ACTIVE;
      run        <= '0;
      busoff_irq <= 1'b0;
    end else begin
      tec        <= tec_n;
      rec        <= rec_n;
      state      <= state_n;
      run        <= run_n;
      busoff_irq <= irq_n;
    end
  end

  // R1
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n) state != 2'b11);
  // R4
  irq_in_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n) busoff_irq |-> state == BUSOFF);
  // R4
  busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state[1]) |-> (tec == 8'd0 && busoff_irq));
  // R7
  ack_no_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PASSIVE && tx_err_inc && ack_err && !wr_any) |=> !state[1]);
  // R8
  rec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off && rec[7] && rx_err_inc && !wr_any) |=> rec == $past(rec));
  // R5
  dominant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && bit_tick && !bit_val && !wr_any) |=> (tec == $past(tec) && state == BUSOFF));
  // R10
  busoff_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !wr_any && !bit_tick) |=> (rec == $past(rec) && tec == $past(tec)));
endmodule

// File: tb/test_can_fault_conf.sv
`timescale 1ns/1ps
module test_can_fault_conf;
  logic clk = 0, rst_n = 0;
  logic tx_err_inc = 0, ack_err = 0, rx_err_inc = 0, tx_ok = 0, rx_ok = 0;
  logic bit_tick = 0, bit_val = 0, test_mode = 0, tec_wr = 0, rec_wr = 0;
  logic [3:0] tx_err_amt = 0, rx_err_amt = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] tec, rec;
  logic [1:0] state;
  logic busoff_irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  can_fault_conf i_can_fault_conf (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    tx_err_inc = 0; ack_err = 0; rx_err_inc = 0; tx_ok = 0; rx_ok = 0;
    bit_tick = 0; test_mode = 0; tec_wr = 0; rec_wr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  task automatic wr_tec(int v);
    test_mode = 1; tec_wr = 1; wr_data = 8'(v); step();
  endtask

  task automatic wr_rec(int v);
    test_mode = 1; rec_wr = 1; wr_data = 8'(v); step();
  endtask

  task automatic tick(logic v);
    bit_tick = 1; bit_val = v; step();
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 tec", tec, 0); chk("R1 rec", rec, 0);
    chk("R1 state", state, 0); chk("R1 irq", busoff_irq, 0);

    tec_wr = 1; wr_data = 55; step();
    chk("R11 write without test_mode", tec, 0);

    for (int t = 0; t < 256; t++) begin
      do_reset();
      wr_tec(t);
      chk("R11 state after load", state, t >= 128 ? 1 : 0);
      tx_err_inc = 1; tx_err_amt = 8; step();
      if (t + 8 > 255) begin
        chk("R4 busoff state", state, 2); chk("R4 tec cleared", tec, 0);
        chk("R4 irq", busoff_irq, 1);
        step();
        chk("R4 irq one cycle", busoff_irq, 0);
      end else begin
        chk("R2 tec", tec, t + 8); chk("R2 state", state, (t + 8 >= 128) ? 1 : 0);
        chk("R2 no irq", busoff_irq, 0);
      end
    end

    for (int r = 0; r < 256; r++) begin
      int v;
      do_reset();
      wr_rec(r);
      rx_err_inc = 1; rx_err_amt = 3; step();
      v = (r > 127) ? r : r + 3;
      chk("R8 rec after error", rec, v);
      chk("R2 rec state", state, v >= 128 ? 1 : 0);
      rx_ok = 1; step();
      v = (v > 127) ? 127 : v - 1;
      chk("R8 rec after success", rec, v);
      chk("R3 state after success", state, 0);
    end

    do_reset();
    tx_ok = 1; rx_ok = 1; step();
    chk("R9 tec floor", tec, 0); chk("R9 rec floor", rec, 0);
    wr_tec(5); wr_rec(5);
    tx_err_inc = 1; tx_err_amt = 1; tx_ok = 1;
    rx_err_inc = 1; rx_err_amt = 2; rx_ok = 1; step();
    chk("R9 tx error wins", tec, 6); chk("R9 rx error wins", rec, 7);
    tx_ok = 1; rx_ok = 1; step();
    chk("R9 tec dec", tec, 5); chk("R9 rec dec", rec, 6);

    do_reset();
    wr_tec(128); wr_rec(128);
    chk("R2 passive", state, 1);
    tx_ok = 1; step();
    chk("R3 still passive", state, 1);
    rx_ok = 1; step();
    chk("R3 back active", state, 0); chk("R3 rec", rec, 127);

    do_reset();
    wr_tec(250);
    tx_err_inc = 1; tx_err_amt = 8; ack_err = 1; step();
    chk("R7 tec held", tec, 255); chk("R7 state", state, 1); chk("R7 irq", busoff_irq, 0);

    do_reset();
    wr_rec(10); wr_tec(250);
    tx_err_inc = 1; tx_err_amt = 8; step();
    chk("R4 enter", state, 2);
    tx_err_inc = 1; rx_err_inc = 1; rx_err_amt = 5; step();
    tx_ok = 1; rx_ok = 1; step();
    chk("R10 tec", tec, 0); chk("R10 rec", rec, 10); chk("R10 state", state, 2);
    for (int i = 0; i < 10; i++) tick(1);
    tick(0);
    chk("R5 dominant leaves tec", tec, 0);
    for (int i = 0; i < 10; i++) tick(1);
    chk("R5 partial run", tec, 0);
    tick(1);
    chk("R5 one run", tec, 1);
    for (int i = 0; i < 11 * 126; i++) tick(1);
    chk("R5 127 runs", tec, 127); chk("R5 still busoff", state, 2);
    chk("R10 rec kept", rec, 10);
    for (int i = 0; i < 11; i++) tick(1);
    chk("R6 state", state, 0); chk("R6 tec", tec, 0); chk("R6 rec", rec, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule